// File: doc/BRIEF.md
# SDRAM Power-Up Sequencer

This block owns the command pins of a single-data-rate SDRAM from reset until the memory can accept ordinary traffic. While the board clock is still settling, it keeps the bus at NOP. Once the `clk_stable` input is seen high, it counts a programmable settling interval, again with only NOPs on the bus. After that interval it walks through a fixed bring-up: it closes every bank, runs two refresh cycles and programs the mode register. Each command is followed by a parameterised quiet gap.

The mode word comes from four configuration inputs: burst length code, burst ordering, CAS latency and single-access writes. The operating-mode field and the upper reserved bits are always packed as zero. A CAS latency request other than 2 is coerced to the legal code for 3. When the final gap has elapsed, `init_done` rises and stays high. The normal controller then takes over the bus.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, the bus carries NOP ({cs_n,ras_n,cas_n,we_n} = 0111), `addr` and `bank` are zero and `init_done` is low.
- R2: While `clk_stable` has not yet been sampled high, the bus carries NOP indefinitely. Counting from the first rising edge that samples `clk_stable` high, exactly `PWR_WAIT_CYC` NOP cycles follow before the first other command.
- R3: The first command after the settling interval is PRECHARGE (0010), with `addr[10]` = 1 to select all banks and every other address bit and `bank` at zero.
- R4: PRECHARGE is followed by exactly `TRP_CYC` NOP cycles and then AUTO REFRESH (0001). That first refresh is followed by exactly `TRFC_CYC` NOP cycles and then a second AUTO REFRESH.
- R5: The second refresh is followed by exactly `TRFC_CYC` NOP cycles and then LOAD MODE (0000). Exactly two refreshes appear between PRECHARGE and LOAD MODE.
- R6: During LOAD MODE, `bank` is zero and `addr` holds the mode word: bits 2:0 = `cfg_burst_len`, bit 3 = `cfg_interleave`, bits 6:4 = CAS latency code, bits 8:7 = 00, bit 9 = `cfg_wr_single`, and bits 12:10 = 0.
- R7: The CAS latency field is 010 when `cfg_cas_lat` is 2 and 011 for every other input value.
- R8: LOAD MODE is followed by exactly `TMRD_CYC` NOP cycles. `init_done` rises in the next cycle, stays high until reset, and the bus then carries only NOP.
- R9: Once the settling count has started, a later drop of `clk_stable` has no effect: the command sequence and its gaps are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_stable | input | 1 | High once the memory clock is within spec |
| cfg_burst_len | input | 3 | Burst length code for the mode word |
| cfg_interleave | input | 1 | Burst ordering: 0 sequential, 1 interleaved |
| cfg_cas_lat | input | 3 | Requested CAS latency (2 or 3) |
| cfg_wr_single | input | 1 | 1 selects single-location writes |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ROW_W | Address bus (mode word during LOAD MODE) |
| sd_bank | output | BANK_W | Bank address |
| init_done | output | 1 | High once bring-up is complete |

## Verification
The bench counts the NOP cycles in every gap exactly. An off-by-one timer would show up as a short or long gap before PRECHARGE, a refresh or the rise of `init_done`. It randomises the mode inputs, including reserved CAS latency values that must come out as code 3. A packer that passed those values through, or let data reach bits 12:10 or 8:7, would give a wrong LOAD MODE address. It also drops `clk_stable` partway through the settling wait, which would catch a sequencer that restarts or stalls. A variable delay before `clk_stable` rises would catch one that issues anything but NOP before the clock is declared stable.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sdr_cmd_t;

    localparam sdr_cmd_t CMD_NOP     = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sdr_cmd_t CMD_PRECHG  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam sdr_cmd_t CMD_REFRESH = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
    localparam sdr_cmd_t CMD_LDMODE  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

    localparam int ALL_BANK_BIT = 10;
    localparam int MODE_USED_W  = 10;

    typedef enum logic [3:0] {
        ST_UNSTABLE,
        ST_SETTLE,
        ST_PRECHG,
        ST_GAP_RP,
        ST_REF_A,
        ST_GAP_RFC_A,
        ST_REF_B,
        ST_GAP_RFC_B,
        ST_LDMODE,
        ST_GAP_MRD,
        ST_READY
    } init_state_t;

    typedef struct packed {
        logic [2:0] burst_len;
        logic       interleave;
        logic [2:0] cas_lat;
        logic       wr_single;
    } mode_cfg_t;

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic logic [2:0] cas_code(input logic [2:0] req);
        return (req == 3'd2) ? 3'b010 : 3'b011;
    endfunction

    function automatic sdr_cmd_t cmd_for_state(input init_state_t st);
        case (st)
            ST_PRECHG: return CMD_PRECHG;
            ST_REF_A:  return CMD_REFRESH;
            ST_REF_B:  return CMD_REFRESH;
            ST_LDMODE: return CMD_LDMODE;
            default:   return CMD_NOP;
        endcase
    endfunction

endpackage

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sdram_mode_packer.sv
module sdram_mode_packer
    import sdram_init_pkg::*;
#(
    parameter int ROW_W = 13
) (
    input  mode_cfg_t        cfg,
    output logic [ROW_W-1:0] word
);
    assign word[2:0] = cfg.burst_len;
    assign word[3]   = cfg.interleave;
    assign word[6:4] = cas_code(cfg.cas_lat);
    assign word[8:7] = 2'b00;
    assign word[9]   = cfg.wr_single;

    generate
        if (ROW_W > MODE_USED_W) begin : g_upper_zero
            assign word[ROW_W-1:MODE_USED_W] = '0;
        end
    endgenerate
endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
    import sdram_init_pkg::*;
#(
    parameter int PWR_WAIT_CYC = 10000,
    parameter int TRP_CYC      = 2,
    parameter int TRFC_CYC     = 7,
    parameter int TMRD_CYC     = 2,
    parameter int ROW_W        = 13,
    parameter int CNT_W        = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_stable,
    input  logic             gap_expired,
    input  logic [ROW_W-1:0] mode_word,
    output logic             gap_load,
    output logic [CNT_W-1:0] gap_val,
    output sdr_cmd_t         cmd_q,
    output logic [ROW_W-1:0] addr_q,
    output logic             done_q
);
    init_state_t state_q, state_d;

    always_comb begin
        state_d  = state_q;
        gap_load = 1'b0;
        gap_val  = '0;
        case (state_q)
            ST_UNSTABLE: if (clk_stable) begin
                state_d  = ST_SETTLE;
                gap_load = 1'b1;
                gap_val  = CNT_W'(PWR_WAIT_CYC - 1);
            end
            ST_SETTLE:    if (gap_expired) state_d = ST_PRECHG;
            ST_PRECHG: begin
                state_d  = ST_GAP_RP;
                gap_load = 1'b1;
                gap_val  = CNT_W'(TRP_CYC - 1);
            end
            ST_GAP_RP:    if (gap_expired) state_d = ST_REF_A;
            ST_REF_A: begin
                state_d  = ST_GAP_RFC_A;
                gap_load = 1'b1;
                gap_val  = CNT_W'(TRFC_CYC - 1);
            end
            ST_GAP_RFC_A: if (gap_expired) state_d = ST_REF_B;
            ST_REF_B: begin
                state_d  = ST_GAP_RFC_B;
                gap_load = 1'b1;
                gap_val  = CNT_W'(TRFC_CYC - 1);
            end
            ST_GAP_RFC_B: if (gap_expired) state_d = ST_LDMODE;
            ST_LDMODE: begin
                state_d  = ST_GAP_MRD;
                gap_load = 1'b1;
                gap_val  = CNT_W'(TMRD_CYC - 1);
            end
            ST_GAP_MRD:   if (gap_expired) state_d = ST_READY;
            ST_READY:     state_d = ST_READY;
            default:      state_d = ST_UNSTABLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_UNSTABLE;
            cmd_q   <= CMD_NOP;
            addr_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cmd_q   <= cmd_for_state(state_d);
            done_q  <= (state_d == ST_READY);
            if (state_d == ST_PRECHG)
                addr_q <= ROW_W'(1) << ALL_BANK_BIT;
            else if (state_d == ST_LDMODE)
                addr_q <= mode_word;
            else
                addr_q <= '0;
        end
    end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int PWR_WAIT_CYC = 10000,
    parameter int TRP_CYC      = 2,
    parameter int TRFC_CYC     = 7,
    parameter int TMRD_CYC     = 2,
    parameter int ROW_W        = 13,
    parameter int BANK_W       = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_stable,
    input  logic [2:0]        cfg_burst_len,
    input  logic              cfg_interleave,
    input  logic [2:0]        cfg_cas_lat,
    input  logic              cfg_wr_single,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ROW_W-1:0]  sd_addr,
    output logic [BANK_W-1:0] sd_bank,
    output logic              init_done
);
    localparam int LONGEST = max_of4(PWR_WAIT_CYC, TRP_CYC, TRFC_CYC, TMRD_CYC);
    localparam int CNT_W   = $clog2(LONGEST + 1);

    mode_cfg_t        cfg;
    logic [ROW_W-1:0] mode_word;
    logic             gap_load;
    logic [CNT_W-1:0] gap_val;
    logic             gap_expired;
    sdr_cmd_t         cmd;

    assign cfg = '{burst_len: cfg_burst_len, interleave: cfg_interleave,
                   cas_lat: cfg_cas_lat, wr_single: cfg_wr_single};

    sdram_mode_packer #(.ROW_W(ROW_W)) u_pack (
        .cfg  (cfg),
        .word (mode_word)
    );

    sdram_gap_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (gap_load),
        .load_val (gap_val),
        .expired  (gap_expired)
    );

    sdram_init_fsm #(
        .PWR_WAIT_CYC (PWR_WAIT_CYC),
        .TRP_CYC      (TRP_CYC),
        .TRFC_CYC     (TRFC_CYC),
        .TMRD_CYC     (TMRD_CYC),
        .ROW_W        (ROW_W),
        .CNT_W        (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .clk_stable  (clk_stable),
        .gap_expired (gap_expired),
        .mode_word   (mode_word),
        .gap_load    (gap_load),
        .gap_val     (gap_val),
        .cmd_q       (cmd),
        .addr_q      (sd_addr),
        .done_q      (init_done)
    );

    assign sd_cs_n  = cmd.cs_n;
    assign sd_ras_n = cmd.ras_n;
    assign sd_cas_n = cmd.cas_n;
    assign sd_we_n  = cmd.we_n;
    assign sd_bank  = '0;
endmodule

// File: rtl/sdram_init_checker.sv
module sdram_init_checker #(
    parameter int ROW_W  = 13,
    parameter int BANK_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [ROW_W-1:0]  sd_addr,
    input logic [BANK_W-1:0] sd_bank,
    input logic              init_done
);
    logic [3:0] bus;
    assign bus = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (bus == 4'b0111 && !init_done && sd_addr == '0));

    assert_legal_cmd_R3: assert property (@(posedge clk) disable iff (rst)
        (bus == 4'b0111 || bus == 4'b0010 || bus == 4'b0001 || bus == 4'b0000));

    assert_prechg_all_R3: assert property (@(posedge clk) disable iff (rst)
        (bus == 4'b0010) |-> (sd_addr[10] && sd_bank == '0));

    assert_prechg_gap_R4: assert property (@(posedge clk) disable iff (rst)
        (bus == 4'b0010) |=> (bus == 4'b0111));

    assert_mode_reserved_R6: assert property (@(posedge clk) disable iff (rst)
        (bus == 4'b0000) |-> (sd_addr[12:10] == 3'b000 && sd_addr[8:7] == 2'b00 && sd_bank == '0));

    assert_mode_cas_R7: assert property (@(posedge clk) disable iff (rst)
        (bus == 4'b0000) |-> (sd_addr[6:4] == 3'b010 || sd_addr[6:4] == 3'b011));

    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    assert_done_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        init_done |-> (bus == 4'b0111));
endmodule

bind sdram_init_seq sdram_init_checker #(.ROW_W(ROW_W), .BANK_W(BANK_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_addr   (sd_addr),
    .sd_bank   (sd_bank),
    .init_done (init_done)
);

// File: tb/sim_sdram_init_seq.sv
module sim_sdram_init_seq;
    localparam int PWR  = 20;
    localparam int TRP  = 3;
    localparam int TRFC = 5;
    localparam int TMRD = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clk_stable = 1'b0;
    logic [2:0] cfg_bl = 3'd0;
    logic cfg_il = 1'b0;
    logic [2:0] cfg_cl = 3'd2;
    logic cfg_ws = 1'b0;
    logic cs_n, ras_n, cas_n, we_n, done;
    logic [12:0] addr;
    logic [1:0] bank;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    sdram_init_seq #(
        .PWR_WAIT_CYC(PWR), .TRP_CYC(TRP), .TRFC_CYC(TRFC), .TMRD_CYC(TMRD),
        .ROW_W(13), .BANK_W(2)
    ) u0 (
        .clk(clk), .rst(rst), .clk_stable(clk_stable),
        .cfg_burst_len(cfg_bl), .cfg_interleave(cfg_il),
        .cfg_cas_lat(cfg_cl), .cfg_wr_single(cfg_ws),
        .sd_cs_n(cs_n), .sd_ras_n(ras_n), .sd_cas_n(cas_n), .sd_we_n(we_n),
        .sd_addr(addr), .sd_bank(bank), .init_done(done)
    );

    function automatic logic [3:0] bus();
        return {cs_n, ras_n, cas_n, we_n};
    endfunction

    function automatic logic [12:0] exp_mode(input logic [2:0] bl, input logic il,
                                             input logic [2:0] cl, input logic ws);
        logic [2:0] c;
        c = (cl == 3'd2) ? 3'b010 : 3'b011;
        return {3'b000, ws, 2'b00, c, il, bl};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // count NOP cycles until a non-NOP command; returns the command seen
    task automatic count_gap(output int nops, output logic [3:0] cmd, input int drop_at);
        nops = 0;
        cmd  = 4'b0111;
        for (int k = 0; k < 500; k++) begin
            @(negedge clk);
            if (drop_at >= 0 && k == drop_at) clk_stable = 1'b0;
            if (bus() != 4'b0111) begin
                cmd = bus();
                return;
            end
            nops++;
        end
    endtask

    task automatic run_one(input logic [2:0] bl, input logic il, input logic [2:0] cl,
                           input logic ws, input int pre_delay, input int drop_at);
        int g;
        logic [3:0] c;
        cfg_bl = bl; cfg_il = il; cfg_cl = cl; cfg_ws = ws;
        rst = 1'b1; clk_stable = 1'b0;
        repeat (3) @(negedge clk);
        check(bus() == 4'b0111 && !done && addr == 0, "R1 in reset", {bus(), 3'b0, done}, 32'h70);
        rst = 1'b0;
        @(negedge clk);
        check(bus() == 4'b0111 && !done && addr == 0 && bank == 0, "R1 after reset",
              {bus(), 3'b0, done}, 32'h70);
        for (int k = 0; k < pre_delay; k++) begin
            @(negedge clk);
            check(bus() == 4'b0111 && !done, "R2 hold while unstable", bus(), 4'b0111);
        end
        clk_stable = 1'b1;
        count_gap(g, c, drop_at);
        check(g == PWR, "R2 settle length", g, PWR);
        check(drop_at < 0 || g == PWR, "R9 drop ignored", g, PWR);
        check(c == 4'b0010, "R3 precharge cmd", c, 4'b0010);
        check(addr == 13'h400 && bank == 0, "R3 all-bank address", addr, 13'h400);
        count_gap(g, c, -1);
        check(g == TRP && c == 4'b0001, "R4 tRP gap then refresh", {g, c}, {TRP, 4'b0001});
        count_gap(g, c, -1);
        check(g == TRFC && c == 4'b0001, "R4 tRFC gap then refresh", {g, c}, {TRFC, 4'b0001});
        count_gap(g, c, -1);
        check(g == TRFC && c == 4'b0000, "R5 tRFC gap then mode load", {g, c}, {TRFC, 4'b0000});
        check(addr == exp_mode(bl, il, cl, ws) && bank == 0, "R6 mode word",
              addr, exp_mode(bl, il, cl, ws));
        check(addr[6:4] == ((cl == 3'd2) ? 3'b010 : 3'b011), "R7 cas code",
              addr[6:4], (cl == 3'd2) ? 3'b010 : 3'b011);
        for (int k = 0; k < TMRD; k++) begin
            @(negedge clk);
            check(bus() == 4'b0111 && !done, "R8 tMRD quiet, done low", {bus(), 3'b0, done}, 32'h70);
        end
        @(negedge clk);
        check(done, "R8 done rises", done, 1);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check(done && bus() == 4'b0111, "R8 done sticky, NOP", {bus(), 3'b0, done}, 32'h71);
        end
    endtask

    initial begin : watchdog
        wait (cycles > 150000);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
        $finish;
    end

    initial begin : stim
        int seed;
        seed = 32'h5d7a11;
        void'($urandom(seed));
        // directed corner cases
        run_one(3'd3, 1'b0, 3'd2, 1'b0, 0, -1);    // R7 CL2, no delay
        run_one(3'd7, 1'b1, 3'd3, 1'b1, 9, -1);    // R6 all fields set
        run_one(3'd0, 1'b0, 3'd7, 1'b0, 2, 4);     // R7 reserved CL, R9 drop
        run_one(3'd2, 1'b1, 3'd0, 1'b1, 1, 0);     // R9 drop right away
        for (int i = 0; i < 40; i++) begin
            logic [2:0] bl;
            logic [2:0] cl;
            bl = 3'($urandom_range(7));
            cl = 3'($urandom_range(7));
            run_one(bl, 1'($urandom_range(1)), cl, 1'($urandom_range(1)),
                    $urandom_range(6),
                    ($urandom_range(3) == 0) ? int'($urandom_range(PWR - 1)) : -1);
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule